// File: doc/BRIEF.md
# Bi-phase Forward Frame Receiver

This block takes the receive line of a two-wire lighting control bus, after optical isolation, and recovers the commands that a controller sends to a slave. The line rests high. Each frame opens with a start bit of value 1 and carries two bytes, address first, each sent most significant bit first. Every bit is split into two half-bit periods of nominal length Te. A 1 is sent as a low half followed by a high half. A 0 is sent as a high half followed by a low half.

Before the block looks at the line, it passes the line through a two-flop synchroniser. It then counts clock cycles between successive edges. At each edge it classes the interval just ended as one half-bit or two, and it turns the resulting half-bit levels into bits. The frame closes when the line stays high beyond the longest legal pulse. A good frame gives address and data with a single-cycle strobe. A malformed frame gives a single-cycle error pulse instead. After an error the receiver ignores the line for a fixed recovery window, which is 1.7 ms in real time, and then waits for a new start edge.

Te (`TE_CYCLES`) and the recovery window (`RECOVER_CYCLES`) are parameters given in clock cycles. Below, LMAX stands for 2·TE_CYCLES + (2·TE_CYCLES)/5.

Top module: `biphase_fwd_rx`

## Requirements
- R1: In reset and afterwards, until the first frame ends, `frame_valid` and `frame_error` are 0 and `frame_addr` and `frame_data` are 0.
- R2: Bit 1 is a low half then a high half. Bit 0 is a high half then a low half. The idle line is high and the first bit is a start bit of value 1. For a well-formed frame, `frame_addr` holds the 8 bits after the start bit and `frame_data` holds the next 8, both MSB first, and they are valid in the cycle `frame_valid` is 1.
- R3: `frame_valid` is a one-cycle pulse. It rises exactly LMAX+4 clock cycles after the final rising edge of the frame reaches `rx_line`. It never occurs in the same cycle as `frame_error`.
- R4: An interval between edges is accepted as one half-bit when it lies in [TE−TE/5, TE+TE/5] cycles. It is accepted as two half-bits when it lies in [2TE−2TE/5, LMAX] cycles. Frames made of intervals at these limits decode as in R2.
- R5: An interval outside both ranges of R4 raises a one-cycle `frame_error` 3 cycles after the edge that ends it reaches `rx_line`, and gives no strobe. So does a low level held beyond LMAX cycles. A long interval that would place two equal halves in one bit, and a bit whose two halves are equal, are also violations.
- R6: If the line goes idle after fewer than or more than 17 bits (counting the start bit), the frame is rejected with `frame_error` and no strobe. If an 18th bit completes on an edge, the error comes 3 cycles after that edge. Otherwise it comes LMAX+4 cycles after the final rising edge.
- R7: After `frame_error`, the block ignores edges for `RECOVER_CYCLES` cycles. A start edge that reaches `rx_line` `RECOVER_CYCLES`−2 cycles after the error cycle, or later, is accepted.
- R8: `frame_addr` and `frame_data` change only in a cycle where `frame_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Isolated bus receive line, asynchronous, high when idle |
| frame_valid | output | 1 | One-cycle strobe for a frame accepted |
| frame_addr | output | 8 | Address byte of the last accepted frame |
| frame_data | output | 8 | Data byte of the last accepted frame |
| frame_error | output | 1 | One-cycle pulse for a frame rejected |

## Verification
The bench drives frames whose half-bits all sit at the lower or at the upper tolerance limit, and frames whose half-bits alternate short and long. A decoder with an off-by-one range would raise errors on these frames. A lone 49-cycle pulse and a low level held for 200 cycles must each raise an error on the exact cycle. Frames of 16 and 18 bits must be rejected, and the 18-bit frame is sent with each possible last-bit value, so a bit counter that accepts any length, or checks it at the wrong moment, shows up as a missed or misplaced pulse. A stray pulse inside the recovery window must be ignored, and a frame that starts right at the end of the window must be accepted. A receiver that is not deaf during recovery would emit a spurious error here, and one that recovers late would lose that frame.

// File: rtl/biphase_rx_pkg.sv
package biphase_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_FRAME   = 2'd1,
    RX_RECOVER = 2'd2
  } rx_state_t;

  typedef enum logic [1:0] {
    PW_BAD   = 2'd0,
    PW_SHORT = 2'd1,
    PW_LONG  = 2'd2
  } pw_class_t;
endpackage

// File: rtl/biphase_sync.sv
module biphase_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rst_n_sync,
  output logic line_lvl,
  output logic line_prev,
  output logic edge_any,
  output logic edge_fall
);
  logic [1:0]             rst_ff;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_sync = rst_ff[1];

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], rx_in};

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign line_lvl  = sync_q[SYNC_STAGES-1];
  assign line_prev = prev_q;
  assign edge_any  = line_lvl ^ line_prev;
  assign edge_fall = line_prev & ~line_lvl;
endmodule

// File: rtl/biphase_width_class.sv
module biphase_width_class
  import biphase_rx_pkg::*;
#(
  parameter int TE_CYCLES = 41667,
  parameter int CNT_W     = 20
) (
  input  logic [CNT_W-1:0] width,
  output pw_class_t        pw_cls
);
  localparam int SHORT_MIN = TE_CYCLES - TE_CYCLES / 5;
  localparam int SHORT_MAX = TE_CYCLES + TE_CYCLES / 5;
  localparam int LONG_MIN  = 2 * TE_CYCLES - (2 * TE_CYCLES) / 5;
  localparam int LONG_MAX  = 2 * TE_CYCLES + (2 * TE_CYCLES) / 5;

  localparam logic [CNT_W-1:0] SMIN_C = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] SMAX_C = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] LMIN_C = CNT_W'(LONG_MIN);
  localparam logic [CNT_W-1:0] LMAX_C = CNT_W'(LONG_MAX);

  always_comb begin
    if (width >= SMIN_C && width <= SMAX_C)      pw_cls = PW_SHORT;
    else if (width >= LMIN_C && width <= LMAX_C) pw_cls = PW_LONG;
    else                                         pw_cls = PW_BAD;
  end
endmodule

// File: rtl/biphase_frame_fsm.sv
module biphase_frame_fsm
  import biphase_rx_pkg::*;
#(
  parameter int TE_CYCLES      = 41667,
  parameter int RECOVER_CYCLES = 170000,
  parameter int BYTE_W         = 8,
  parameter int CNT_W          = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_lvl,
  input  logic              line_prev,
  input  logic              edge_any,
  input  logic              edge_fall,
  input  pw_class_t         pw_cls,
  output logic [CNT_W-1:0]  pulse_width,
  output logic              frame_valid,
  output logic              frame_error,
  output logic [BYTE_W-1:0] frame_addr,
  output logic [BYTE_W-1:0] frame_data
);
  localparam int LONG_MAX = 2 * TE_CYCLES + (2 * TE_CYCLES) / 5;
  localparam int NBITS    = 2 * BYTE_W + 1;
  localparam int NB_W     = $clog2(NBITS + 1);

  localparam logic [CNT_W-1:0] LMAX_C  = CNT_W'(LONG_MAX);
  localparam logic [CNT_W-1:0] REC_C   = CNT_W'(RECOVER_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [NB_W-1:0]  NBITS_C = NB_W'(NBITS);
  localparam logic [NB_W-1:0]  NBM1_C  = NB_W'(NBITS - 1);

  rx_state_t         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              pend_v_q, pend_v_d;
  logic              pend_l_q, pend_l_d;
  logic [NB_W-1:0]   nbits_q, nbits_d;
  logic [NBITS-1:0]  shreg_q, shreg_d;
  logic              valid_q, valid_d;
  logic              err_q, err_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;

  logic              viol, take_bit, finish, bit_val;
  logic [NBITS-1:0]  word;

  assign pulse_width = cnt_q;
  assign cnt_inc     = (cnt_q == '1) ? cnt_q : cnt_q + CNT_ONE;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    pend_v_d = pend_v_q;
    pend_l_d = pend_l_q;
    nbits_d  = nbits_q;
    shreg_d  = shreg_q;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    addr_d   = addr_q;
    data_d   = data_q;
    viol     = 1'b0;
    take_bit = 1'b0;
    finish   = 1'b0;
    bit_val  = 1'b0;
    word     = shreg_q;

    case (state_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (edge_fall) begin
          state_d  = RX_FRAME;
          cnt_d    = CNT_ONE;
          pend_v_d = 1'b0;
          nbits_d  = '0;
          shreg_d  = '0;
        end
      end

      RX_FRAME: begin
        if (edge_any) begin
          // the level before this edge lasted pulse_width cycles
          cnt_d = CNT_ONE;
          case (pw_cls)
            PW_SHORT: begin
              if (pend_v_q) begin
                take_bit = 1'b1;
                pend_v_d = 1'b0;
              end else begin
                pend_v_d = 1'b1;
                pend_l_d = line_prev;
              end
            end
            PW_LONG: begin
              if (pend_v_q) begin
                take_bit = 1'b1;
                pend_v_d = 1'b1;
                pend_l_d = line_prev;
              end else begin
                viol = 1'b1;
              end
            end
            default: viol = 1'b1;
          endcase
          if (take_bit) begin
            if (pend_l_q == line_prev) begin
              viol = 1'b1;
            end else if (nbits_q == NBITS_C) begin
              viol = 1'b1;
            end else begin
              bit_val = ~pend_l_q;
              shreg_d = {shreg_q[NBITS-2:0], bit_val};
              nbits_d = nbits_q + NB_W'(1);
            end
          end
        end else begin
          cnt_d = cnt_inc;
          if (cnt_q > LMAX_C) begin
            if (!line_lvl) begin
              viol = 1'b1;
            end else if (pend_v_q && !pend_l_q && nbits_q == NBM1_C) begin
              word   = {shreg_q[NBITS-2:0], 1'b1};
              finish = 1'b1;
            end else if (!pend_v_q && nbits_q == NBITS_C) begin
              word   = shreg_q;
              finish = 1'b1;
            end else begin
              viol = 1'b1;
            end
          end
        end

        if (finish && word[NBITS-1]) begin
          state_d = RX_IDLE;
          valid_d = 1'b1;
          addr_d  = word[2*BYTE_W-1:BYTE_W];
          data_d  = word[BYTE_W-1:0];
        end else if (finish) begin
          viol = 1'b1;
        end

        if (viol) begin
          state_d = RX_RECOVER;
          cnt_d   = CNT_ONE;
          err_d   = 1'b1;
        end
      end

      RX_RECOVER: begin
        cnt_d = cnt_inc;
        if (cnt_q >= REC_C) state_d = RX_IDLE;
      end

      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      pend_v_q <= 1'b0;
      pend_l_q <= 1'b0;
      nbits_q  <= '0;
      shreg_q  <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      pend_v_q <= pend_v_d;
      pend_l_q <= pend_l_d;
      nbits_q  <= nbits_d;
      shreg_q  <= shreg_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
      if (valid_d) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign frame_valid = valid_q;
  assign frame_error = err_q;
  assign frame_addr  = addr_q;
  assign frame_data  = data_q;
endmodule

// File: rtl/biphase_fwd_rx.sv
module biphase_fwd_rx
  import biphase_rx_pkg::*;
#(
  parameter int TE_CYCLES      = 41667,
  parameter int RECOVER_CYCLES = 170000,
  parameter int BYTE_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  output logic              frame_valid,
  output logic [BYTE_W-1:0] frame_addr,
  output logic [BYTE_W-1:0] frame_data,
  output logic              frame_error
);
  localparam int LONG_MAX = 2 * TE_CYCLES + (2 * TE_CYCLES) / 5;
  localparam int CNT_TOP  = (RECOVER_CYCLES > LONG_MAX + 1) ? RECOVER_CYCLES : LONG_MAX + 1;
  localparam int CNT_W    = $clog2(CNT_TOP + 1) + 1;

  logic             rst_n_sync, line_lvl, line_prev, edge_any, edge_fall;
  logic [CNT_W-1:0] pulse_width;
  pw_class_t        pw_cls;

  biphase_sync #(.SYNC_STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_line),
    .rst_n_sync(rst_n_sync),
    .line_lvl  (line_lvl),
    .line_prev (line_prev),
    .edge_any  (edge_any),
    .edge_fall (edge_fall)
  );

  biphase_width_class #(.TE_CYCLES(TE_CYCLES), .CNT_W(CNT_W)) u_class (
    .width (pulse_width),
    .pw_cls(pw_cls)
  );

  biphase_frame_fsm #(
    .TE_CYCLES     (TE_CYCLES),
    .RECOVER_CYCLES(RECOVER_CYCLES),
    .BYTE_W        (BYTE_W),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .line_lvl   (line_lvl),
    .line_prev  (line_prev),
    .edge_any   (edge_any),
    .edge_fall  (edge_fall),
    .pw_cls     (pw_cls),
    .pulse_width(pulse_width),
    .frame_valid(frame_valid),
    .frame_error(frame_error),
    .frame_addr (frame_addr),
    .frame_data (frame_data)
  );
endmodule

// File: rtl/biphase_fwd_rx_chk.sv
module biphase_fwd_rx_chk #(
  parameter int TE_CYCLES      = 41667,
  parameter int RECOVER_CYCLES = 170000,
  parameter int BYTE_W         = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_line,
  input logic              frame_valid,
  input logic [BYTE_W-1:0] frame_addr,
  input logic [BYTE_W-1:0] frame_data,
  input logic              frame_error
);
  localparam int LONG_MAX = 2 * TE_CYCLES + (2 * TE_CYCLES) / 5;

  logic [31:0] hi_cnt, since_err;
  logic        seen_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      since_err <= '0;
      seen_err  <= 1'b0;
    end else begin
      if (!rx_line)              hi_cnt <= '0;
      else if (hi_cnt != '1)     hi_cnt <= hi_cnt + 32'd1;
      if (frame_error) begin
        since_err <= '0;
        seen_err  <= 1'b1;
      end else if (since_err != '1) begin
        since_err <= since_err + 32'd1;
      end
    end
  end

  // R3: strobe lasts one cycle
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R3: strobe and error never together
  a_r3_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_error));

  // R3: a frame only completes after the line has idled past the long limit
  a_r3_valid_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (hi_cnt > 32'(LONG_MAX)));

  // R5: error is a single-cycle pulse
  a_r5_error_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);

  // R7: no second error inside the recovery window
  a_r7_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_error && seen_err) |-> (since_err >= 32'(RECOVER_CYCLES)));

  // R8: outputs move only with the strobe
  a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(frame_addr) && $stable(frame_data)));
endmodule

bind biphase_fwd_rx biphase_fwd_rx_chk #(
  .TE_CYCLES     (TE_CYCLES),
  .RECOVER_CYCLES(RECOVER_CYCLES),
  .BYTE_W        (BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_line    (rx_line),
  .frame_valid(frame_valid),
  .frame_addr (frame_addr),
  .frame_data (frame_data),
  .frame_error(frame_error)
);

// File: tb/biphase_fwd_rx_test.sv
module biphase_fwd_rx_test;
  localparam int TE   = 40;
  localparam int REC  = 163;
  localparam int LMAX = 2 * TE + (2 * TE) / 5;
  localparam int EV_VALID = 1;
  localparam int EV_ERROR = 2;

  logic       clk, rst_n, rx_line;
  logic       frame_valid, frame_error;
  logic [7:0] frame_addr, frame_data;

  int    cyc;
  int    n_cmp, n_bad;
  bit    done;
  string cur_req;

  int         ev_cyc[$];
  int         ev_kind[$];
  logic [7:0] ev_a[$];
  logic [7:0] ev_d[$];
  string      ev_tag[$];

  logic [7:0] held_a, held_d;
  logic       exp_v, exp_e;
  string      chk_tag;

  biphase_fwd_rx #(.TE_CYCLES(TE), .RECOVER_CYCLES(REC), .BYTE_W(8)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .frame_valid(frame_valid),
    .frame_addr (frame_addr),
    .frame_data (frame_data),
    .frame_error(frame_error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle reference comparison; outputs hold between strobes (R8)
  initial begin
    held_a = 8'h00;
    held_d = 8'h00;
  end
  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_v   = 1'b0;
      exp_e   = 1'b0;
      chk_tag = cur_req;
      while (ev_cyc.size() > 0 && ev_cyc[0] < cyc) begin
        void'(ev_cyc.pop_front()); void'(ev_kind.pop_front());
        void'(ev_a.pop_front()); void'(ev_d.pop_front()); void'(ev_tag.pop_front());
      end
      if (ev_cyc.size() > 0 && ev_cyc[0] == cyc) begin
        chk_tag = ev_tag[0];
        if (ev_kind[0] == EV_VALID) begin
          exp_v  = 1'b1;
          held_a = ev_a[0];
          held_d = ev_d[0];
        end else begin
          exp_e = 1'b1;
        end
        void'(ev_cyc.pop_front()); void'(ev_kind.pop_front());
        void'(ev_a.pop_front()); void'(ev_d.pop_front()); void'(ev_tag.pop_front());
      end
      n_cmp++;
      if (frame_valid !== exp_v || frame_error !== exp_e ||
          frame_addr !== held_a || frame_data !== held_d) begin
        n_bad++;
        $display("FAIL %s cycle %0d: valid=%b err=%b addr=%h data=%h, expected valid=%b err=%b addr=%h data=%h",
                 chk_tag, cyc, frame_valid, frame_error, frame_addr, frame_data,
                 exp_v, exp_e, held_a, held_d);
      end
    end
  end

  task automatic expect_ev(input int c, input int kind, input logic [7:0] a,
                           input logic [7:0] d, input string tag);
    ev_cyc.push_back(c);
    ev_kind.push_back(kind);
    ev_a.push_back(a);
    ev_d.push_back(d);
    ev_tag.push_back(tag);
  endtask

  // called at a falling clock edge; line changes now and holds n cycles
  task automatic set_level(input logic l, input int n);
    rx_line = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    repeat (LMAX + REC + 20) @(negedge clk);
  endtask

  // start bit, nd bits MSB first; half i lasts base -/+ jit
  task automatic send_frame(input int nd, input logic [31:0] bits, input int base,
                            input int jit, output int c_last);
    logic lv[$];
    int   du[$];
    int   k;
    logic l;
    int   d;
    lv.push_back(1'b0);
    lv.push_back(1'b1);
    for (int i = nd - 1; i >= 0; i--) begin
      if (bits[i]) begin lv.push_back(1'b0); lv.push_back(1'b1); end
      else         begin lv.push_back(1'b1); lv.push_back(1'b0); end
    end
    for (int i = 0; i < lv.size(); i++) du.push_back(base + (((i % 2) == 1) ? jit : -jit));
    if (lv[lv.size()-1] == 1'b1) begin
      void'(lv.pop_back());
      void'(du.pop_back());
    end
    k = 0;
    while (k < lv.size()) begin
      l = lv[k];
      d = 0;
      while (k < lv.size() && lv[k] == l) begin
        d = d + du[k];
        k++;
      end
      set_level(l, d);
    end
    rx_line = 1'b1;
    c_last  = cyc;
  endtask

  task automatic frame_ok(input logic [7:0] a, input logic [7:0] d, input int base,
                          input int jit, input string tag);
    int cl;
    send_frame(16, {16'h0000, a, d}, base, jit, cl);
    expect_ev(cl + LMAX + 4, EV_VALID, a, d, tag);
    settle();
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, cycle %0d, expected end before 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      done = 1'b1;
      $finish;
    end
  end

  initial begin
    int c0, e0, cl;
    n_cmp   = 0;
    n_bad   = 0;
    cur_req = "R1";
    rx_line = 1'b1;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2 R3: nominal timing, assorted bit patterns
    cur_req = "R2";
    frame_ok(8'hA5, 8'h3C, TE, 0, "R2 R3");
    frame_ok(8'h00, 8'hFF, TE, 0, "R2 R3");
    frame_ok(8'hFF, 8'h00, TE, 0, "R2 R3");
    frame_ok(8'h55, 8'hAA, TE, 0, "R2 R3");

    // R4: tolerance limits
    cur_req = "R4";
    frame_ok(8'hC3, 8'h81, TE, 8, "R4 alternating 32/48");
    frame_ok(8'h7E, 8'h01, 48, 0, "R4 upper limits");
    frame_ok(8'h12, 8'hF0, 32, 0, "R4 lower limits");

    // R5: a 49-cycle pulse is neither short nor long
    cur_req = "R5";
    c0 = cyc;
    expect_ev(c0 + 49 + 3, EV_ERROR, 8'h00, 8'h00, "R5 bad width");
    set_level(1'b0, 49);
    rx_line = 1'b1;
    settle();
    frame_ok(8'h3A, 8'h5C, TE, 0, "R5 next frame decodes");

    // R5 then R7: stuck low, stray pulse in recovery, start at window end
    cur_req = "R7";
    c0 = cyc;
    e0 = c0 + LMAX + 4;
    expect_ev(e0, EV_ERROR, 8'h00, 8'h00, "R5 low too long");
    set_level(1'b0, 200);
    set_level(1'b1, 10);
    set_level(1'b0, TE);
    rx_line = 1'b1;
    while (cyc < e0 + REC - 2) @(negedge clk);
    frame_ok(8'h96, 8'h69, TE, 0, "R7 start at end of recovery");

    // R6: wrong bit counts
    cur_req = "R6";
    send_frame(15, 32'h0000_5A3B, TE, 0, cl);
    expect_ev(cl + LMAX + 4, EV_ERROR, 8'h00, 8'h00, "R6 16 bits");
    settle();
    send_frame(17, 32'h0001_2344, TE, 0, cl);
    expect_ev(cl + 3, EV_ERROR, 8'h00, 8'h00, "R6 18 bits ending 0");
    settle();
    send_frame(17, 32'h0001_2345, TE, 0, cl);
    expect_ev(cl + LMAX + 4, EV_ERROR, 8'h00, 8'h00, "R6 18 bits ending 1");
    settle();

    cur_req = "R8";
    frame_ok(8'hE7, 8'h18, TE, 0, "R8 R2 final frame");
    repeat (20) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule